// File: doc/BRIEF.md
# Branch Condition Resolution Unit

This block decides whether a relative or absolute branch is taken and computes every architectural side effect the branch produces. It accepts one decoded branch per strobe: the address of the branch itself, whether it is unconditional or conditional, a five-bit option field and a five-bit bit selector, a link flag, an absolute-address flag, a displacement, and the current values of the 32-bit condition register and count register. It returns the taken decision, the target address, a new count value with its write enable, and a return address with its write enable.

A conditional branch combines two tests. The first reads one bit of the condition register and compares it with a wanted sense. The second optionally decrements the count register and compares the decremented value with zero. Either test can be bypassed by its own option bit. The branch goes only when both tests pass. All results are combinational, so they appear in the same cycle the strobe is raised, and the write enables are held low whenever no strobe is present.

Top module: `brc_unit`

## Requirements
- R1: A conditional branch is taken exactly when the condition-register test and the counter test both pass.
- R2: When option bit 4 (value 16) is 1, the condition-register test passes regardless of the register contents.
- R3: When option bit 4 is 0, selector value n picks condition-register bit 31-n (n = 0 is the MSB); the test passes if that bit is 1 with option bit 3 (value 8) set, or is 0 with option bit 3 clear.
- R4: When option bit 2 (value 4) is 0 on a conditional branch, the count write enable is 1 and the new count is the old count minus one modulo 2^32, whether or not the branch is taken.
- R5: When option bit 2 is 1, or the branch is unconditional, the count write enable is 0, and with bit 2 set the counter test passes.
- R6: When decrementing, option bit 1 (value 2) = 0 makes the counter test pass if the decremented count is non-zero; bit 1 = 1 makes it pass if the decremented count is zero.
- R7: Option bit 0 (value 1) has no effect on any output.
- R8: Kind 0 (unconditional) is always taken with target = address + sign-extended (24-bit displacement << 2); kind 1 (conditional) uses target = address + sign-extended (low 14 displacement bits << 2).
- R9: With the absolute flag set, the target is the sign-extended shifted displacement alone.
- R10: With the link flag set, the link write enable is 1 and the link value is address + 4, for both kinds; with the link flag clear the link write enable is 0.
- R11: While the strobe is low, taken, both write enables and the valid output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| br_valid_i | input | 1 | Strobe: a branch is presented this cycle |
| br_kind_i | input | 1 | 0 = unconditional, 1 = conditional |
| br_pc_i | input | 32 | Address of the branch |
| br_opt_i | input | 5 | Option field selecting tests and counter use |
| br_sel_i | input | 5 | Condition-register bit selector |
| br_link_i | input | 1 | Record the return address |
| br_abs_i | input | 1 | Displacement is an absolute address |
| br_disp_i | input | 24 | Word displacement; conditional uses bits 13:0 |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 32 | Count register |
| res_valid_o | output | 1 | Results are valid |
| taken_o | output | 1 | Branch is taken |
| target_o | output | 32 | Branch target address |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_next_o | output | 32 | New count value |
| lr_we_o | output | 1 | Link register write enable |
| lr_next_o | output | 32 | Return address to record |

## Verification
Every result of this block is due in the same cycle the branch is presented, with zero register stages between inputs and outputs. The bench therefore applies each branch on the falling clock edge, waits a quarter period for the combinational paths to settle, and compares all outputs before the next rising edge; a fresh branch is never applied until the previous one has been compared. Idle cycles with the strobe low are interleaved so the gating of the enables is checked at the same sampling point.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned OPT_W   = 5;
  localparam int unsigned LONG_W  = 24;
  localparam int unsigned SHORT_W = 14;

  // option field bit positions; the decision logic depends on them
  localparam int unsigned OPT_CR_ANY  = 4;
  localparam int unsigned OPT_CR_SET  = 3;
  localparam int unsigned OPT_CTR_OFF = 2;
  localparam int unsigned OPT_CTR_ZRO = 1;

  typedef enum logic {
    KIND_UNCOND = 1'b0,
    KIND_COND   = 1'b1
  } br_kind_e;
endpackage

// File: rtl/brc_cr_test.sv
module brc_cr_test #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SEL_W = 5
) (
  input  logic [XLEN-1:0]  cr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             any_i,
  input  logic             want_set_i,
  output logic             pass_o
);
  localparam int unsigned TOP = XLEN - 1;

  logic picked;

  always_comb begin
    picked = cr_i[TOP - int'(sel_i)];
    pass_o = any_i | (picked == want_set_i);
  end

  always_comb begin
    a_r2_any_passes: assert (!any_i || pass_o);
  end
endmodule

// File: rtl/brc_ctr_test.sv
module brc_ctr_test #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] ctr_i,
  input  logic            off_i,
  input  logic            want_zero_i,
  output logic [XLEN-1:0] ctr_dec_o,
  output logic            pass_o
);
  logic dec_is_zero;

  always_comb begin
    ctr_dec_o   = ctr_i - XLEN'(1);
    dec_is_zero = (ctr_dec_o == '0);
    pass_o      = off_i | (dec_is_zero == want_zero_i);
  end

  always_comb begin
    a_r6_zero_means_one: assert (off_i || !want_zero_i || !pass_o || ctr_i == XLEN'(1));
  end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned LONG_W  = 24,
  parameter int unsigned SHORT_W = 14
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [LONG_W-1:0] disp_i,
  input  logic              short_i,
  input  logic              abs_i,
  output logic [XLEN-1:0]   target_o,
  output logic [XLEN-1:0]   ret_o
);
  localparam int unsigned LPAD = XLEN - LONG_W - 2;
  localparam int unsigned SPAD = XLEN - SHORT_W - 2;

  logic [XLEN-1:0] off_long;
  logic [XLEN-1:0] off_short;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] base;

  always_comb begin
    off_long  = {{LPAD{disp_i[LONG_W-1]}}, disp_i, 2'b00};
    off_short = {{SPAD{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0], 2'b00};
    offset    = short_i ? off_short : off_long;
    base      = abs_i ? '0 : pc_i;
    target_o  = base + offset;
    ret_o     = pc_i + XLEN'(4);
  end

  always_comb begin
    a_r8_word_aligned: assert (abs_i || target_o[1:0] == pc_i[1:0]);
  end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
(
  input  logic               br_valid_i,
  input  logic               br_kind_i,
  input  logic [XLEN-1:0]    br_pc_i,
  input  logic [OPT_W-1:0]   br_opt_i,
  input  logic [OPT_W-1:0]   br_sel_i,
  input  logic               br_link_i,
  input  logic               br_abs_i,
  input  logic [LONG_W-1:0]  br_disp_i,
  input  logic [XLEN-1:0]    cr_i,
  input  logic [XLEN-1:0]    ctr_i,
  output logic               res_valid_o,
  output logic               taken_o,
  output logic [XLEN-1:0]    target_o,
  output logic               ctr_we_o,
  output logic [XLEN-1:0]    ctr_next_o,
  output logic               lr_we_o,
  output logic [XLEN-1:0]    lr_next_o
);
  br_kind_e        kind;
  logic            cr_pass;
  logic            ctr_pass;
  logic [XLEN-1:0] ctr_dec;
  logic [XLEN-1:0] ret_addr;
  logic            is_cond;
  logic            dec_en;

  assign kind = br_kind_e'(br_kind_i);

  brc_cr_test #(.XLEN(XLEN), .SEL_W(OPT_W)) u_cr (
    .cr_i       (cr_i),
    .sel_i      (br_sel_i),
    .any_i      (br_opt_i[OPT_CR_ANY]),
    .want_set_i (br_opt_i[OPT_CR_SET]),
    .pass_o     (cr_pass)
  );

  brc_ctr_test #(.XLEN(XLEN)) u_ctr (
    .ctr_i       (ctr_i),
    .off_i       (br_opt_i[OPT_CTR_OFF]),
    .want_zero_i (br_opt_i[OPT_CTR_ZRO]),
    .ctr_dec_o   (ctr_dec),
    .pass_o      (ctr_pass)
  );

  brc_target #(.XLEN(XLEN), .LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_tgt (
    .pc_i     (br_pc_i),
    .disp_i   (br_disp_i),
    .short_i  (kind == KIND_COND),
    .abs_i    (br_abs_i),
    .target_o (target_o),
    .ret_o    (ret_addr)
  );

  always_comb begin
    is_cond     = (kind == KIND_COND);
    dec_en      = is_cond & ~br_opt_i[OPT_CTR_OFF];
    res_valid_o = br_valid_i;
    taken_o     = br_valid_i & (~is_cond | (cr_pass & ctr_pass));
    ctr_we_o    = br_valid_i & dec_en;
    ctr_next_o  = dec_en ? ctr_dec : ctr_i;
    lr_we_o     = br_valid_i & br_link_i;
    lr_next_o   = ret_addr;
  end

  always_comb begin
    a_r1_needs_both: assert (!(taken_o && is_cond) || (cr_pass && ctr_pass));
    a_r4_minus_one: assert (!ctr_we_o || ctr_next_o + XLEN'(1) == ctr_i);
    a_r5_no_write: assert (!(br_opt_i[OPT_CTR_OFF] || !is_cond) || !ctr_we_o);
    a_r8_uncond_goes: assert (!(br_valid_i && !is_cond) || taken_o);
    a_r10_link_addr: assert (!lr_we_o || lr_next_o == br_pc_i + XLEN'(4));
    a_r11_idle_quiet: assert (br_valid_i || !(taken_o || ctr_we_o || lr_we_o));
  end
endmodule

// File: tb/brc_unit_test.sv
module brc_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        v, kind, link, absf;
  logic [31:0] pc, cr, ctr;
  logic [4:0]  opt, sel;
  logic [23:0] disp;
  logic        res_valid, taken, ctr_we, lr_we;
  logic [31:0] target, ctr_next, lr_next;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brc_unit uut (
    .br_valid_i(v), .br_kind_i(kind), .br_pc_i(pc), .br_opt_i(opt),
    .br_sel_i(sel), .br_link_i(link), .br_abs_i(absf), .br_disp_i(disp),
    .cr_i(cr), .ctr_i(ctr), .res_valid_o(res_valid), .taken_o(taken),
    .target_o(target), .ctr_we_o(ctr_we), .ctr_next_o(ctr_next),
    .lr_we_o(lr_we), .lr_next_o(lr_next)
  );

  function automatic bit exp_taken();
    bit crok, cok;
    logic [31:0] d;
    if (!v) return 1'b0;
    if (!kind) return 1'b1;
    crok = opt[4] ? 1'b1 : (cr[31 - sel] == opt[3]);
    d = ctr - 32'd1;
    cok = opt[2] ? 1'b1 : (opt[1] ? (d == 0) : (d != 0));
    return crok && cok;
  endfunction

  function automatic logic [31:0] exp_target();
    logic [31:0] off;
    if (kind) off = {{16{disp[13]}}, disp[13:0], 2'b00};
    else      off = {{6{disp[23]}}, disp, 2'b00};
    return absf ? off : pc + off;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    bit dec;
    dec = v && kind && !opt[2];
    cmp(req, "valid", {31'd0, res_valid}, {31'd0, v});
    cmp(req, "taken", {31'd0, taken}, {31'd0, exp_taken()});
    if (v && taken) cmp(req, "target", target, exp_target());
    cmp(req, "ctr_we", {31'd0, ctr_we}, {31'd0, dec});
    if (dec) cmp(req, "ctr_next", ctr_next, ctr - 32'd1);
    cmp(req, "lr_we", {31'd0, lr_we}, {31'd0, v && link});
    if (v && link) cmp(req, "lr_next", lr_next, pc + 32'd4);
  endtask

  task automatic apply(bit vv, bit k, logic [4:0] o, logic [4:0] s, bit l,
                       bit a, logic [23:0] dd, logic [31:0] c, logic [31:0] n,
                       logic [31:0] p, string req);
    @(negedge clk);
    v = vv; kind = k; opt = o; sel = s; link = l; absf = a; disp = dd;
    cr = c; ctr = n; pc = p;
    #(CLK_PERIOD/4);
    check_all(req);
  endtask

  initial begin
    v = 0; kind = 0; opt = 0; sel = 0; link = 0; absf = 0; disp = 0;
    cr = 0; ctr = 0; pc = 0;
    #(CLK_PERIOD/4);
    check_all("R11");
    // R8 unconditional forward/backward
    apply(1, 0, 5'd0, 5'd0, 0, 0, 24'h000010, 0, 5, 32'h1000, "R8");
    apply(1, 0, 5'd0, 5'd0, 0, 0, 24'hFFFFFC, 0, 5, 32'h1000, "R8");
    apply(1, 1, 5'b10100, 5'd0, 0, 0, 24'h002001, 0, 5, 32'h4000, "R8");
    // R9 absolute
    apply(1, 0, 5'd0, 5'd0, 0, 1, 24'h800000, 0, 5, 32'h1234, "R9");
    apply(1, 1, 5'b10100, 5'd0, 0, 1, 24'h000040, 0, 5, 32'h1234, "R9");
    // R10 link both kinds, and none
    apply(1, 0, 5'd0, 5'd0, 1, 0, 24'h1, 0, 0, 32'h2000, "R10");
    apply(1, 1, 5'b00000, 5'd3, 1, 0, 24'h1, 0, 2, 32'h2000, "R10");
    apply(1, 1, 5'b10100, 5'd3, 0, 0, 24'h1, 0, 2, 32'h2000, "R10");
    // R2 always-pass ignores CR
    apply(1, 1, 5'b10100, 5'd0, 0, 0, 24'h4, 32'h0, 1, 32'h100, "R2");
    apply(1, 1, 5'b10100, 5'd0, 0, 0, 24'h4, 32'hFFFFFFFF, 1, 32'h100, "R2");
    // R3 bit selection, sel 0 is MSB; sel 31 is LSB
    apply(1, 1, 5'b01100, 5'd0, 0, 0, 24'h4, 32'h80000000, 1, 32'h100, "R3");
    apply(1, 1, 5'b00100, 5'd0, 0, 0, 24'h4, 32'h80000000, 1, 32'h100, "R3");
    apply(1, 1, 5'b01100, 5'd31, 0, 0, 24'h4, 32'h00000001, 1, 32'h100, "R3");
    apply(1, 1, 5'b01100, 5'd31, 0, 0, 24'h4, 32'h80000000, 1, 32'h100, "R3");
    // R4/R6 counter: count 1 and 2, both senses, wrap at 0
    apply(1, 1, 5'b10000, 5'd0, 0, 0, 24'h4, 0, 32'd1, 32'h100, "R6");
    apply(1, 1, 5'b10000, 5'd0, 0, 0, 24'h4, 0, 32'd2, 32'h100, "R6");
    apply(1, 1, 5'b10010, 5'd0, 0, 0, 24'h4, 0, 32'd1, 32'h100, "R6");
    apply(1, 1, 5'b10010, 5'd0, 0, 0, 24'h4, 0, 32'd2, 32'h100, "R4");
    apply(1, 1, 5'b10000, 5'd0, 0, 0, 24'h4, 0, 32'd0, 32'h100, "R4");
    // R1 CR fails but counter passes
    apply(1, 1, 5'b01000, 5'd0, 0, 0, 24'h4, 32'h0, 32'd2, 32'h100, "R1");
    // R5 no decrement
    apply(1, 1, 5'b00110, 5'd0, 0, 0, 24'h4, 32'h0, 32'd7, 32'h100, "R5");
    // R7 hint bit
    apply(1, 1, 5'b00001, 5'd0, 1, 0, 24'h4, 32'h0, 32'd2, 32'h100, "R7");
    apply(1, 1, 5'b00000, 5'd0, 1, 0, 24'h4, 32'h0, 32'd2, 32'h100, "R7");
    // R11 idle with enables-provoking fields
    apply(0, 1, 5'b00000, 5'd0, 1, 0, 24'h4, 32'h0, 32'd2, 32'h100, "R11");
    // randomized mix; exhaustive-style sweep of option/count/cond combinations
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      apply(($urandom % 8) != 0, $urandom % 2, 5'($urandom), 5'($urandom),
            $urandom % 2, ($urandom % 4) == 0, 24'($urandom), $urandom,
            (($urandom % 3) == 0) ? 32'($urandom % 3) : $urandom, $urandom,
            "R1");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule